// File: doc/BRIEF.md
# E1 Sa6 error statistics counter

This block keeps a performance-monitoring count of error-indication events carried in the Sa6 spare bits of a received E1 stream. In its main mode it counts received CRC submultiframes whose four Sa6 bits carry one of two error codes. The count is only taken while the receiver holds multiframe alignment, and it stops at its maximum value instead of wrapping. In the split mode the same storage holds two separate event counters. One counts multiframe periods spent without alignment. The other counts changes of frame or multiframe alignment.

Software reads the count as a low byte and a high byte. With latch mode on, a one-second tick copies the running count into a held register and clears the running count in the same cycle. Software then has a full second to read a stable value. With latch mode off, the readable value follows the live count. A small read-port state machine makes a low-byte read followed by a high-byte read return one coherent 16-bit value.

The read-port state machine has two states. `RD_LIVE` passes the live high byte through. `RD_HELD` returns the high byte captured at the last low-byte read. The transitions are:
- LIVE-to-HELD on a low-byte read.
- HELD-to-HELD on a further low-byte read, which captures again.
- HELD-to-LIVE on a high-byte read.

The counting mode is a two-valued selector, `MODE_SA6` (0) or `MODE_SPLIT` (1). It has no transitions of its own.

Top module: `sa6_err_stat`

## Requirements
- R1: In mode 0, with CRC multiframe enabled and multiframe alignment held (`lmfa` low), each cycle with `smf_stb` high and `sa6_bits` equal to 4'b0010 or 4'b0011 adds one to the count. `sa6_bits[3]` is SA61 and `sa6_bits[0]` is SA64. Any other nibble adds nothing.
- R2: In mode 0 without alarm simulation, no strobe changes the count while `lmfa` is high.
- R3: In mode 0, no strobe changes the count while `crc_mf_en` is low (doubleframe format).
- R4: In mode 0 the count saturates at 16'hFFFF and never wraps to zero.
- R5: With `latch_en` high, a cycle with `sec_tick` high copies the running count into the readable register and clears the running count. The readable value stays unchanged until the next tick.
- R6: An increment in the same cycle as a latching tick is applied to the cleared running count, so the new running count is 1 and the event is not lost.
- R7: In mode 0 with `alarm_sim` high and `crc_mf_en` high, every `smf_stb` adds one. This happens whatever the Sa6 nibble and the `lmfa` state are, up to saturation.
- R8: In mode 1, each `mf_stb` while `lfa` or `lmfa` is high adds one to a 6-bit counter. The counter saturates at 63 and is read in `cnt_hi[7:2]`.
- R9: In mode 1, each `realign_pulse` adds one to a 2-bit counter. The counter saturates at 3 and is read in `cnt_hi[1:0]`. `cnt_lo` reads zero.
- R10: In mode 1 with `alarm_sim` high, each `mf_stb` adds one to both the 6-bit counter and the 2-bit counter, up to their saturation.
- R11: With `latch_en` low, `{cnt_hi, cnt_lo}` shows the live running count one cycle after each update.
- R12: A cycle with `rd_lo` high captures the current high byte. Until a cycle with `rd_hi` high, `cnt_hi` returns that captured byte. `rd_lo` takes precedence if both are high.
- R13: A synchronous active-high `rst` clears the running count, the latched count and the read-port state, so both bytes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smf_stb | input | 1 | One-cycle strobe per received CRC submultiframe |
| sa6_bits | input | 4 | Received Sa6 nibble, bit 3 = SA61, bit 0 = SA64 |
| mf_stb | input | 1 | One-cycle strobe per multiframe period |
| lmfa | input | 1 | Loss of multiframe alignment |
| lfa | input | 1 | Loss of frame alignment |
| realign_pulse | input | 1 | Change of frame or multiframe alignment detected |
| sec_tick | input | 1 | One-second tick |
| crc_mf_en | input | 1 | CRC multiframe format selected (low = doubleframe) |
| latch_en | input | 1 | Latch-and-clear on one-second tick |
| mode_sel | input | 1 | 0 = Sa6 error count, 1 = split loss/realign counters |
| alarm_sim | input | 1 | Alarm simulation active |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| cnt_lo | output | 8 | Readable count, low byte |
| cnt_hi | output | 8 | Readable count, high byte (coherent after `rd_lo`) |

## Verification
The bench builds the block with its default parameters. These are a 16-bit count, a 6-bit loss field and a 2-bit realign field. Alarm simulation with a strobe every cycle drives the 16-bit count to 65535 in about 65,500 cycles, so the saturation edge is exercised at full width. The narrow mode-1 fields saturate within 70 multiframe strobes, which lets saturation, latch-and-clear coincidence and coherent byte reads all be covered in one short run.

// File: rtl/sa6_stat_pkg.sv
package sa6_stat_pkg;

    localparam int BYTE_W = 8;

    // Sa6 error codes, bit 3 = SA61 ... bit 0 = SA64
    localparam logic [3:0] SA6_CODE_A = 4'b0010;
    localparam logic [3:0] SA6_CODE_B = 4'b0011;

    typedef enum logic {
        MODE_SA6   = 1'b0,
        MODE_SPLIT = 1'b1
    } cnt_mode_e;

    typedef enum logic {
        RD_LIVE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic main;
        logic loss;
        logic aln;
    } inc_req_t;

endpackage

// File: rtl/sa6_sat_inc.sv
module sa6_sat_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         bump,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (bump && (val != {W{1'b1}})) begin
            nxt = val + W'(1);
        end else begin
            nxt = val;
        end
    end
endmodule

// File: rtl/sa6_evt_qual.sv
module sa6_evt_qual
    import sa6_stat_pkg::*;
(
    input  logic      smf_stb,
    input  logic [3:0] sa6_bits,
    input  logic      mf_stb,
    input  logic      lmfa,
    input  logic      lfa,
    input  logic      realign_pulse,
    input  logic      crc_mf_en,
    input  logic      alarm_sim,
    input  cnt_mode_e mode,
    output inc_req_t  req
);
    logic code_hit;

    always_comb begin
        code_hit = (sa6_bits == SA6_CODE_A) || (sa6_bits == SA6_CODE_B);
        req      = '0;
        unique case (mode)
            MODE_SA6: begin
                req.main = smf_stb && crc_mf_en && (alarm_sim || (!lmfa && code_hit));
            end
            MODE_SPLIT: begin
                req.loss = mf_stb && (alarm_sim || lfa || lmfa);
                req.aln  = realign_pulse || (alarm_sim && mf_stb);
            end
        endcase
    end
endmodule

// File: rtl/sa6_run_store.sv
module sa6_run_store
    import sa6_stat_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LOSS_W = 6,
    parameter int ALN_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_mode_e        mode,
    input  inc_req_t         req,
    input  logic             latch_en,
    input  logic             sec_tick,
    output logic [CNT_W-1:0] run_q,
    output logic [CNT_W-1:0] lat_q
);
    localparam int LOW_W = CNT_W - LOSS_W - ALN_W;

    logic             snap;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] main_nxt;
    logic [LOSS_W-1:0] loss_nxt;
    logic [ALN_W-1:0]  aln_nxt;
    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] lat_d;

    assign snap = latch_en && sec_tick;
    assign base = snap ? '0 : run_q;

    sa6_sat_inc #(.W(CNT_W)) u_main (
        .val  (base),
        .bump (req.main),
        .nxt  (main_nxt)
    );

    sa6_sat_inc #(.W(LOSS_W)) u_loss (
        .val  (base[CNT_W-1 -: LOSS_W]),
        .bump (req.loss),
        .nxt  (loss_nxt)
    );

    sa6_sat_inc #(.W(ALN_W)) u_aln (
        .val  (base[LOW_W +: ALN_W]),
        .bump (req.aln),
        .nxt  (aln_nxt)
    );

    always_comb begin
        unique case (mode)
            MODE_SA6:   run_d = main_nxt;
            MODE_SPLIT: run_d = {loss_nxt, aln_nxt, {LOW_W{1'b0}}};
        endcase
        lat_d = snap ? run_q : lat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            lat_q <= '0;
        end else begin
            run_q <= run_d;
            lat_q <= lat_d;
        end
    end
endmodule

// File: rtl/sa6_rd_port.sv
module sa6_rd_port
    import sa6_stat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [CNT_W-1:0]  vis,
    output logic [BYTE_W-1:0] out_lo,
    output logic [CNT_W-BYTE_W-1:0] out_hi
);
    localparam int HI_W = CNT_W - BYTE_W;

    rd_state_e       state_q;
    rd_state_e       state_d;
    logic [HI_W-1:0] shadow_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_LIVE: if (rd_lo) state_d = RD_HELD;
            RD_HELD: begin
                if (rd_lo)      state_d = RD_HELD;
                else if (rd_hi) state_d = RD_LIVE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RD_LIVE;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_lo) shadow_q <= vis[CNT_W-1:BYTE_W];
        end
    end

    always_comb begin
        out_lo = vis[BYTE_W-1:0];
        unique case (state_q)
            RD_LIVE: out_hi = vis[CNT_W-1:BYTE_W];
            RD_HELD: out_hi = shadow_q;
        endcase
    end
endmodule

// File: rtl/sa6_err_stat.sv
module sa6_err_stat
    import sa6_stat_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LOSS_W = 6,
    parameter int ALN_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smf_stb,
    input  logic [3:0]       sa6_bits,
    input  logic             mf_stb,
    input  logic             lmfa,
    input  logic             lfa,
    input  logic             realign_pulse,
    input  logic             sec_tick,
    input  logic             crc_mf_en,
    input  logic             latch_en,
    input  logic             mode_sel,
    input  logic             alarm_sim,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [7:0]       cnt_lo,
    output logic [CNT_W-9:0] cnt_hi
);
    cnt_mode_e        mode;
    inc_req_t         req;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] lat_q;
    logic [CNT_W-1:0] vis_w;

    assign mode  = cnt_mode_e'(mode_sel);
    assign vis_w = latch_en ? lat_q : run_q;

    sa6_evt_qual u_qual (
        .smf_stb       (smf_stb),
        .sa6_bits      (sa6_bits),
        .mf_stb        (mf_stb),
        .lmfa          (lmfa),
        .lfa           (lfa),
        .realign_pulse (realign_pulse),
        .crc_mf_en     (crc_mf_en),
        .alarm_sim     (alarm_sim),
        .mode          (mode),
        .req           (req)
    );

    sa6_run_store #(
        .CNT_W  (CNT_W),
        .LOSS_W (LOSS_W),
        .ALN_W  (ALN_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .req      (req),
        .latch_en (latch_en),
        .sec_tick (sec_tick),
        .run_q    (run_q),
        .lat_q    (lat_q)
    );

    sa6_rd_port #(.CNT_W(CNT_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .vis    (vis_w),
        .out_lo (cnt_lo),
        .out_hi (cnt_hi)
    );
endmodule

// File: rtl/sa6_err_stat_chk.sv
module sa6_err_stat_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_sel,
    input logic             lmfa,
    input logic             crc_mf_en,
    input logic             alarm_sim,
    input logic             latch_en,
    input logic             sec_tick,
    input logic             rd_lo,
    input logic [CNT_W-9:0] cnt_hi,
    input logic [CNT_W-1:0] run_q,
    input logic [CNT_W-1:0] lat_q,
    input logic [CNT_W-1:0] vis_w
);
    // R4
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && (run_q == {CNT_W{1'b1}}) && !(latch_en && sec_tick)) |=> (run_q == {CNT_W{1'b1}}));

    // R2
    a_r2_unsync_hold: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && lmfa && !alarm_sim && !(latch_en && sec_tick)) |=> $stable(run_q));

    // R3
    a_r3_dblframe_idle: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && !crc_mf_en && !(latch_en && sec_tick)) |=> $stable(run_q));

    // R5
    a_r5_latch_copy: assert property (@(posedge clk) disable iff (rst)
        (latch_en && sec_tick) |=> (lat_q == $past(run_q)));

    // R5
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !(latch_en && sec_tick) |=> $stable(lat_q));

    // R9
    a_r9_low_byte_zero: assert property (@(posedge clk) disable iff (rst)
        mode_sel |=> (run_q[7:0] == 8'h00));

    // R12
    a_r12_coherent_hi: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> (cnt_hi == $past(vis_w[CNT_W-1:8])));
endmodule

bind sa6_err_stat sa6_err_stat_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .lmfa      (lmfa),
    .crc_mf_en (crc_mf_en),
    .alarm_sim (alarm_sim),
    .latch_en  (latch_en),
    .sec_tick  (sec_tick),
    .rd_lo     (rd_lo),
    .cnt_hi    (cnt_hi),
    .run_q     (run_q),
    .lat_q     (lat_q),
    .vis_w     (vis_w)
);

// File: tb/tb_sa6_err_stat.sv
`timescale 1ns/1ps
module tb_sa6_err_stat;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, smf_stb, mf_stb, lmfa, lfa, realign_pulse, sec_tick;
    logic crc_mf_en, latch_en, mode_sel, alarm_sim, rd_lo, rd_hi;
    logic [3:0] sa6_bits;
    logic [7:0] cnt_lo, cnt_hi;

    sa6_err_stat dut (
        .clk(clk), .rst(rst), .smf_stb(smf_stb), .sa6_bits(sa6_bits),
        .mf_stb(mf_stb), .lmfa(lmfa), .lfa(lfa), .realign_pulse(realign_pulse),
        .sec_tick(sec_tick), .crc_mf_en(crc_mf_en), .latch_en(latch_en),
        .mode_sel(mode_sel), .alarm_sim(alarm_sim), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R13";

    int m_run, m_lat, m_shadow;
    bit m_held;

    function automatic int vis_m();
        return latch_en ? m_lat : m_run;
    endfunction

    task automatic check(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
        end
    endtask

    // Behavioural model of the next state, applied before each rising edge
    task automatic model_step();
        int  v, base, loss, al;
        bit  hit;
        if (rst) begin
            m_run = 0; m_lat = 0; m_shadow = 0; m_held = 0;
            return;
        end
        v = vis_m();
        if (rd_lo) begin
            m_shadow = v / 256;
            m_held   = 1;
        end else if (rd_hi) begin
            m_held = 0;
        end
        base = (latch_en && sec_tick) ? 0 : m_run;
        if (latch_en && sec_tick) m_lat = m_run;
        if (!mode_sel) begin
            hit = smf_stb && crc_mf_en &&
                  (alarm_sim || (!lmfa && (sa6_bits == 4'd2 || sa6_bits == 4'd3)));
            m_run = (hit && base < 65535) ? base + 1 : base;
        end else begin
            loss = (base / 1024) % 64;
            al   = (base / 256) % 4;
            if (mf_stb && (alarm_sim || lfa || lmfa) && loss < 63) loss++;
            if ((realign_pulse || (alarm_sim && mf_stb)) && al < 3) al++;
            m_run = loss * 1024 + al * 256;
        end
    endtask

    task automatic cycle();
        int v;
        model_step();
        @(negedge clk);
        v = vis_m();
        check(req, int'(cnt_lo), v % 256);
        check(req, int'(cnt_hi), m_held ? m_shadow : v / 256);
    endtask

    task automatic idle();
        smf_stb = 0; mf_stb = 0; lmfa = 0; lfa = 0; realign_pulse = 0;
        sec_tick = 0; crc_mf_en = 1; latch_en = 0; mode_sel = 0;
        alarm_sim = 0; rd_lo = 0; rd_hi = 0; sa6_bits = 4'd0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        cycle();
        cycle();
        rst = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1;
        idle();
        @(negedge clk);
        req = "R13";
        do_reset();
        check("R13", int'(cnt_lo), 0);
        check("R13", int'(cnt_hi), 0);

        req = "R1";
        for (int i = 0; i < 2000; i++) begin
            smf_stb  = ($urandom % 2) == 0;
            sa6_bits = ($urandom % 2) ? {3'b001, 1'($urandom)} : 4'($urandom);
            cycle();
        end

        req = "R2";
        for (int i = 0; i < 1500; i++) begin
            smf_stb  = ($urandom % 2) == 0;
            sa6_bits = {3'b001, 1'($urandom)};
            lmfa     = ($urandom % 3) == 0;
            cycle();
        end
        lmfa = 0;

        req = "R3";
        crc_mf_en = 0;
        for (int i = 0; i < 500; i++) begin
            smf_stb  = 1;
            sa6_bits = 4'd2;
            cycle();
        end
        crc_mf_en = 1;

        req = "R12";
        for (int i = 0; i < 3000; i++) begin
            smf_stb  = ($urandom % 2) == 0;
            sa6_bits = {3'b001, 1'($urandom)};
            rd_lo    = ($urandom % 23) == 0;
            rd_hi    = ($urandom % 19) == 0;
            cycle();
        end
        rd_lo = 0; rd_hi = 1; cycle(); rd_hi = 0;

        req = "R11";
        for (int i = 0; i < 300; i++) begin
            smf_stb = 1; sa6_bits = 4'd3;
            cycle();
        end

        req = "R5";
        latch_en = 1;
        for (int i = 0; i < 4000; i++) begin
            smf_stb  = ($urandom % 3) != 0;
            sa6_bits = 4'd2;
            sec_tick = (i % 97) == 96;
            rd_lo    = ($urandom % 31) == 0;
            rd_hi    = !rd_lo && (($urandom % 29) == 0);
            cycle();
        end
        sec_tick = 0; rd_lo = 0; rd_hi = 1; smf_stb = 0; cycle(); rd_hi = 0;

        req = "R6";
        do_reset();
        latch_en = 1; smf_stb = 1; sa6_bits = 4'd2;
        for (int i = 0; i < 5; i++) cycle();
        sec_tick = 1; cycle();
        sec_tick = 0; smf_stb = 0; latch_en = 0; cycle();
        check("R6", int'(cnt_lo), 1);
        latch_en = 1; cycle();
        check("R6", int'(cnt_lo), 5);

        req = "R7";
        do_reset();
        alarm_sim = 1;
        for (int i = 0; i < 200; i++) begin
            smf_stb  = ($urandom % 2) == 0;
            sa6_bits = 4'($urandom);
            lmfa     = ($urandom % 2) == 0;
            cycle();
        end

        req = "R4";
        do_reset();
        alarm_sim = 1; smf_stb = 1;
        for (int i = 0; i < 65600; i++) cycle();
        alarm_sim = 0; sa6_bits = 4'd2;
        for (int i = 0; i < 20; i++) cycle();
        check("R4", int'(cnt_hi), 255);
        check("R4", int'(cnt_lo), 255);

        req = "R8";
        do_reset();
        mode_sel = 1;
        for (int i = 0; i < 300; i++) begin
            mf_stb = ($urandom % 2) == 0;
            lfa    = ($urandom % 3) == 0;
            lmfa   = ($urandom % 3) == 0;
            cycle();
        end
        lfa = 1; mf_stb = 1;
        for (int i = 0; i < 70; i++) cycle();
        mf_stb = 0; lfa = 0; lmfa = 0;
        check("R8", int'(cnt_hi) / 4, 63);

        req = "R9";
        do_reset();
        mode_sel = 1;
        for (int i = 0; i < 12; i++) begin
            realign_pulse = (i % 3) == 0;
            smf_stb = 1; sa6_bits = 4'd2;
            cycle();
        end
        realign_pulse = 0;
        check("R9", int'(cnt_hi) % 4, 3);
        check("R9", int'(cnt_lo), 0);

        req = "R10";
        do_reset();
        mode_sel = 1; alarm_sim = 1;
        for (int i = 0; i < 150; i++) begin
            mf_stb = ($urandom % 2) == 0;
            cycle();
        end
        check("R10", int'(cnt_hi), 255);

        req = "R13";
        mf_stb = 0; alarm_sim = 0;
        do_reset();
        check("R13", int'(cnt_hi), 0);
        check("R13", int'(cnt_lo), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule